// File: doc/BRIEF.md
# Low-Memory Region Chip Select with Programmable Wait States

This block sits beside a bus controller and claims accesses that fall in a region that starts at address zero. Its size is set by software. When an access inside the region starts, the block drives an active-low select and holds the cycle open for a programmed number of wait states. It then reports that the cycle is done. A configuration bit chooses whether an external ready signal must also be seen before the cycle ends.

The block stays unarmed after reset, so it claims nothing. The first write to its 16-bit configuration register arms it, whatever value that write carries. The register is written through a simple write-enable and data port. The bus side gives a 20-bit address, a one-cycle start strobe and the external ready line.

Top module: `lowmem_cs_top`

## Requirements
- R1: After reset, `sel_n` is 1, `cyc_done` is 0, and the block is unarmed.
- R2: While unarmed, a start strobe has no effect. `sel_n` stays 1 and `cyc_done` stays 0.
- R3: Any register write arms the block, including a write of 16'h0000. An access the cycle after that write is claimed.
- R4: The wait code is {bit 3, bit 1, bit 0} of the register, with bit 3 as the most significant bit. Codes 0 through 7 give 0, 1, 2, 3, 5, 7, 9 and 15 wait states. A claimed access starts on the clock edge that samples the strobe. `sel_n` is then low for waits+1 cycles, and `cyc_done` is high in the last of them.
- R5: When register bit 2 is 1, `ext_rdy` is ignored. The cycle ends after the wait states alone.
- R6: When register bit 2 is 0, `cyc_done` rises only once the wait states have elapsed and `ext_rdy` is 1. While `ext_rdy` is 0 the cycle is stretched and `sel_n` stays low.
- R7: Register bits 14:12 choose the region size. Codes 0, 1 and 2 give 64, 128 and 256 Kbytes, and codes 3 to 7 give 512 Kbytes. An address at or above the size is not claimed.
- R8: A strobe that arrives while a cycle is in progress is ignored.
- R9: The wait code and ready mode are captured when a cycle starts. A register write during the cycle does not change that cycle.
- R10: `sel_n` returns to 1 on the clock edge that follows the `cyc_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 16 | Configuration write data |
| bus_addr | input | 20 | Access address |
| bus_stb | input | 1 | One-cycle access start strobe |
| ext_rdy | input | 1 | External ready |
| sel_n | output | 1 | Active-low region select |
| cyc_done | output | 1 | Cycle completes in this clock |

## Verification
Accesses are run for all eight wait codes with the ready line held low while the ready-ignore bit is set. The select length then shows each code's count, and the low ready line shows that ready is ignored. With ready required, ready is held low past the count and then released, which tells the count-bound end of a cycle from the ready-bound end. Addresses one below and exactly at each region size tell the boundary codes apart. Strobes before and after the arming write, and strobes and writes placed in the middle of a cycle, separate arming from capture and from the idle-only start.

// File: rtl/lmcs_pkg.sv
package lmcs_pkg;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 4;
  localparam int UB_MAX = 3;

  // Non-linear wait-code map
  function automatic logic [CNT_W-1:0] wait_count(input logic [2:0] code);
    logic [CNT_W-1:0] w;
    case (code)
      3'd4:    w = CNT_W'(5);
      3'd5:    w = CNT_W'(7);
      3'd6:    w = CNT_W'(9);
      3'd7:    w = CNT_W'(15);
      default: w = CNT_W'(code);
    endcase
    return w;
  endfunction

  // Region size in bytes (exclusive limit), one bit wider than the address
  function automatic logic [ADDR_W:0] region_size(input logic [2:0] ub);
    logic [1:0] sh;
    sh = (ub > 3'(UB_MAX)) ? 2'(UB_MAX) : ub[1:0];
    return (ADDR_W+1)'(32'h1_0000) << sh;
  endfunction
endpackage

// File: rtl/lmcs_cfg_reg.sv
module lmcs_cfg_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cfg,
  output logic             armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      armed <= 1'b0;
    end else if (we) begin
      cfg   <= wdata;
      armed <= 1'b1;
    end
  end

  // R3
  arm_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n) we |=> armed);
  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) armed |=> armed);
endmodule

// File: rtl/lmcs_decode.sv
module lmcs_decode
  import lmcs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        ub,
  input  logic              stb,
  input  logic              armed,
  input  logic              idle,
  output logic              in_region,
  output logic              start
);
  assign in_region = ({1'b0, addr} < region_size(ub));
  assign start     = stb && armed && idle && in_region;
endmodule

// File: rtl/lmcs_wait_ctr.sv
module lmcs_wait_ctr
  import lmcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] code,
  input  logic       rdy_ignore,
  input  logic       ext_rdy,
  output logic       busy,
  output logic       cnt_zero,
  output logic       done
);
  logic [CNT_W-1:0] cnt;
  logic             ign_q;

  assign cnt_zero = (cnt == '0);
  assign done     = busy && cnt_zero && (ign_q || ext_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      ign_q <= 1'b0;
    end else if (busy) begin
      if (done)          busy <= 1'b0;
      else if (!cnt_zero) cnt <= cnt - 1'b1;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= wait_count(code);
      ign_q <= rdy_ignore;
    end
  end

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_zero) |=> (busy && cnt == $past(cnt) - 1'b1));
  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_zero && !ign_q && !ext_rdy) |=> busy);
  // R10
  end_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/lowmem_cs_top.sv
module lowmem_cs_top
  import lmcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_stb,
  input  logic              ext_rdy,
  output logic              sel_n,
  output logic              cyc_done
);
  logic [15:0] cfg;
  logic        armed, in_region, start, busy, cnt_zero;
  logic [2:0]  wcode;

  assign wcode = {cfg[3], cfg[1:0]};

  lmcs_cfg_reg #(.REG_W(16)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .armed(armed)
  );

  lmcs_decode u_dec (
    .addr(bus_addr), .ub(cfg[14:12]), .stb(bus_stb), .armed(armed),
    .idle(!busy), .in_region(in_region), .start(start)
  );

  lmcs_wait_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .code(wcode),
    .rdy_ignore(cfg[2]), .ext_rdy(ext_rdy), .busy(busy),
    .cnt_zero(cnt_zero), .done(cyc_done)
  );

  assign sel_n = !busy;

  // R2
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (sel_n && !cyc_done));
  // R4
  claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sel_n);
  // R8
  busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !cyc_done) |=> !sel_n);
endmodule

// File: tb/sim_lowmem_cs_top.sv
module sim_lowmem_cs_top;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, bus_stb = 0, ext_rdy = 1;
  logic [15:0] cfg_wdata = 0;
  logic [19:0] bus_addr = 0;
  logic        sel_n, cyc_done;

  always #5 clk = ~clk;

  lowmem_cs_top u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_stb(bus_stb), .ext_rdy(ext_rdy),
    .sel_n(sel_n), .cyc_done(cyc_done));

  int checks = 0, fails = 0;
  int waits_tab[8] = '{0, 1, 2, 3, 5, 7, 9, 15};
  bit m_armed = 0, m_busy = 0, m_ign = 0;
  int m_left = 0;
  logic [15:0] m_cfg = 0;
  string tag = "R1";

  function automatic int size_of(logic [15:0] c);
    int u = c[14:12];
    if (u > 3) u = 3;
    return 65536 * (1 << u);
  endfunction

  function automatic bit exp_done();
    return m_busy && m_left == 0 && (m_ign || ext_rdy);
  endfunction

  task automatic check(string t, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit d;
    #1;
    check(tag, sel_n, !m_busy, "sel_n");
    check(tag, cyc_done, exp_done(), "cyc_done");
    @(posedge clk);
    d = exp_done();
    if (m_busy) begin
      if (d) m_busy = 0;
      else if (m_left > 0) m_left--;
    end else if (bus_stb && m_armed && int'(bus_addr) < size_of(m_cfg)) begin
      m_busy = 1;
      m_left = waits_tab[{m_cfg[3], m_cfg[1:0]}];
      m_ign  = m_cfg[2];
    end
    if (cfg_we) begin m_armed = 1; m_cfg = cfg_wdata; end
    @(negedge clk);
    bus_stb = 0;
    cfg_we  = 0;
  endtask

  task automatic wr(logic [15:0] v);
    cfg_we = 1; cfg_wdata = v; step();
  endtask

  task automatic access(logic [19:0] a, int n);
    bus_addr = a; bus_stb = 1;
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic [15:0] mk(int ub, bit ign, int code);
    return 16'((ub << 12) | ((code >> 2) << 3) | (ign << 2) | (code & 3));
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", sel_n, 1'b1, "reset sel_n");
    check("R1", cyc_done, 1'b0, "reset cyc_done");
    rst_n = 1;
    @(negedge clk);
    step();
    tag = "R2";  access(20'h00010, 4);
    tag = "R3";  wr(16'h0000); access(20'h00000, 3);
    tag = "R4";
    ext_rdy = 0;
    for (int c = 0; c < 8; c++) begin
      wr(mk(0, 1, c)); access(20'h00100, waits_tab[c] + 3);
    end
    tag = "R5";  wr(mk(0, 1, 2)); access(20'h00004, 5);
    tag = "R6";
    for (int c = 0; c < 3; c += 2) begin
      wr(mk(0, 0, c)); ext_rdy = 0; access(20'h00008, waits_tab[c] + 5);
      ext_rdy = 1; step(); step(); step();
    end
    tag = "R7";
    for (int u = 0; u < 5; u++) begin
      int s = 65536 * (1 << ((u > 3) ? 3 : u));
      wr(mk(u, 1, 1)); access(20'(s - 1), 4);
      if (s < 1048576) access(20'(s), 4);
    end
    tag = "R8";  wr(mk(3, 1, 4)); access(20'h00200, 3); access(20'h00300, 6);
    tag = "R9";  wr(mk(3, 1, 7)); access(20'h00040, 2); wr(mk(3, 0, 0));
    ext_rdy = 0; for (int i = 0; i < 16; i++) step();
    ext_rdy = 1;
    tag = "R10"; wr(mk(0, 1, 0)); access(20'h00001, 1); access(20'h00002, 4);
    finish_run();
  end
endmodule